// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt and Register Decoder

This block sits between a byte-wide host bus and two IDE drive interfaces on an expansion card. The host presents an address with a one-cycle read or write strobe. The block decodes that address into a chip-select, a 3-bit register index and a control-block flag for the drive interface being addressed. It also keeps an interrupt-enable latch for each channel, shows the raw drive interrupt requests as status bits, and merges the enabled requests into a single card interrupt.

A write-only configuration byte at address zero does two jobs. Bit 5 opens the secondary window that holds all per-channel registers. Bit 0 steers the card's single DMA request/acknowledge pair to channel 2 when set, and to channel 1 when clear. While the window is closed, the block serves the board identification path. A 4-bit board code is spread one bit per byte, in bit 0 of four bytes. Writing zero to the configuration byte returns the card to that state, so the identification path can be read again.

Software arms a channel by writing any value to that channel's interrupt-control address, and disarms it by reading the same address. Read data is combinational and valid while the read strobe is high. The side effects of a read or write take hold at the clock edge that samples the strobe.

Top module: `ide2_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, both interrupt-enable latches are clear, the window is closed and the DMA path points at channel 1 (`card_irq`=0, `win_en`=0, `dma_ch`=0).
- R2: With the window closed, a read of address 0x2280+4*i (i=0..3) returns bit i of the board code in data bit 0, with all other bits zero. The board code is 3, so the four reads give 1, 1, 0, 0.
- R3: A write to address 0 loads `win_en` from data bit 5 and `dma_ch` from data bit 0 at that clock edge. The other data bits have no effect. Writing 0 closes the window.
- R4: With the window closed, no channel register decodes. No chip-select is raised, writes to interrupt-control addresses leave the latches unchanged, and reads return zero.
- R5: With the window open, a write of any value to 0x2200 (channel 1) or 0x3200 (channel 2) sets that channel's enable latch. A read of the same address clears it and returns zero.
- R6: `card_irq` is high exactly when some channel has both its raw request and its enable latch high. A latch keeps its state while the window is closed.
- R7: A read of 0x2290 (channel 1) or 0x3290 (channel 2) returns the raw request of that channel in bit 0, whatever the enable state, with all other bits zero.
- R8: A strobe to base+64*k, where k=0..7 and base is 0x2000 for channel 1 or 0x3000 for channel 2, raises `tf_cs` bit 0 (channel 1) or bit 1 (channel 2). It drives `tf_reg`=k, `tf_alt`=0 and `tf_rd`/`tf_wr` following the strobe. A read returns `tf_rdata`. At most one chip-select is high.
- R9: A strobe to 0x2380 (channel 1) or 0x3380 (channel 2) raises that channel's chip-select with `tf_alt`=1 and `tf_reg`=0.
- R10: Addresses that decode to nothing read as zero and raise no chip-select. This includes misaligned taskfile offsets, and the identification bytes while the window is open. `bus_rdata` is zero whenever no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 14 | Host byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| drv_irq | input | 2 | Raw drive interrupt requests, bit 0 = channel 1 |
| tf_rdata | input | 8 | Data returned by the selected drive interface |
| card_irq | output | 1 | Combined card interrupt |
| tf_cs | output | 2 | Drive interface chip-selects, bit 0 = channel 1 |
| tf_alt | output | 1 | Selects the control block (alternate status / device control) |
| tf_reg | output | 3 | Taskfile register index |
| tf_rd | output | 1 | Read strobe to the selected interface |
| tf_wr | output | 1 | Write strobe to the selected interface |
| win_en | output | 1 | Secondary window open |
| dma_ch | output | 1 | DMA path steered to channel 2 when high |

## Verification
The bench uses the default parameters: 14 address bits, 6-bit register stepping, channel bases 0x2000 and 0x3000, identification base 0x2280 and board code 3. With these values the exact decode boundaries can be probed. These are the last taskfile slot at offset 0x1C0, an address one byte past an aligned slot, an address just past the taskfile span, and addresses below a channel base, where the relative offset wraps. The stepping and bases are fixed at these values, so the same bench sequence also covers every bit of the board code, including both the set and the clear bits.

// File: rtl/ide2_pkg.sv
package ide2_pkg;
  localparam int unsigned NCH        = 2;      // drive interfaces on the card
  localparam int unsigned TF_REGS    = 8;      // taskfile registers per channel
  localparam int unsigned REG_W      = $clog2(TF_REGS);
  localparam int unsigned ICTL_OFS   = 'h200;  // interrupt arm/disarm, channel relative
  localparam int unsigned STAT_OFS   = 'h290;  // raw request status, channel relative
  localparam int unsigned ALT_OFS    = 'h380;  // control block, channel relative
  localparam int unsigned ID_STRIDE  = 4;      // spacing of identification bytes
endpackage

// File: rtl/ide2_addr_dec.sv
module ide2_addr_dec
  import ide2_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned STEP     = 6,
  parameter int unsigned CH1_BASE = 'h2000,
  parameter int unsigned CH2_BASE = 'h3000,
  parameter int unsigned ID_BASE  = 'h2280,
  parameter int unsigned ID_BITS  = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               win_en,
  output logic [NCH-1:0]     tf_hit,
  output logic [NCH-1:0]     alt_hit,
  output logic [NCH-1:0]     ictl_hit,
  output logic [NCH-1:0]     stat_hit,
  output logic [ID_BITS-1:0] id_hit,
  output logic               cfg_hit,
  output logic [REG_W-1:0]   tf_idx
);
  localparam int unsigned TF_SPAN = TF_REGS << STEP;

  logic [REG_W-1:0] idx [NCH];

  // per-channel window decode, offsets taken relative to each channel base
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = (c == 0) ? CH1_BASE : CH2_BASE;
    logic [ADDR_W-1:0] rel;
    assign rel         = addr - ADDR_W'(BASE);
    assign tf_hit[c]   = win_en && (rel < ADDR_W'(TF_SPAN)) && (rel[STEP-1:0] == '0);
    assign alt_hit[c]  = win_en && (rel == ADDR_W'(ALT_OFS));
    assign ictl_hit[c] = win_en && (rel == ADDR_W'(ICTL_OFS));
    assign stat_hit[c] = win_en && (rel == ADDR_W'(STAT_OFS));
    assign idx[c]      = rel[STEP+REG_W-1:STEP];
  end

  // identification bytes live only on the path seen with the window closed
  for (genvar i = 0; i < ID_BITS; i++) begin : g_id
    assign id_hit[i] = !win_en && (addr == ADDR_W'(ID_BASE + ID_STRIDE * i));
  end

  assign cfg_hit = (addr == '0);

  always_comb begin
    tf_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      if (tf_hit[c]) tf_idx = idx[c];
    end
  end
endmodule

// File: rtl/ide2_irq_ctrl.sv
module ide2_irq_ctrl
  import ide2_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [NCH-1:0] ictl_hit,
  output logic [NCH-1:0] irq_en
);
  for (genvar c = 0; c < NCH; c++) begin : g_lat
    logic en_ld;
    logic en_nxt;

    // a write arms, a read disarms; a write wins if both strobes appear
    always_comb begin
      en_ld  = ictl_hit[c] && (bus_wr || bus_rd);
      en_nxt = bus_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     irq_en[c] <= 1'b0;
      else if (en_ld) irq_en[c] <= en_nxt;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ictl_hit[c]) |=> irq_en[c]);                              // R5
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && ictl_hit[c]) |=> !irq_en[c]);                  // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ictl_hit[c] && (bus_rd || bus_wr)) |=> $stable(irq_en[c]));        // R4
  end
endmodule

// File: rtl/ide2_cfg_reg.sv
module ide2_cfg_reg #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned WIN_BIT = 5,
  parameter int unsigned DMA_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              win_en,
  output logic              dma_ch
);
  logic win_nxt;
  logic dma_nxt;
  logic unused_wbits;

  always_comb begin
    win_nxt = wdata[WIN_BIT];
    dma_nxt = wdata[DMA_BIT];
  end

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en <= 1'b0;
      dma_ch <= 1'b0;
    end else if (we) begin
      win_en <= win_nxt;
      dma_ch <= dma_nxt;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({win_en, dma_ch}));                                    // R3
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (win_en == $past(wdata[WIN_BIT])) && (dma_ch == $past(wdata[DMA_BIT]))); // R3
endmodule

// File: rtl/ide2_decoder.sv
module ide2_decoder
  import ide2_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned STEP     = 6,
  parameter int unsigned CH1_BASE = 'h2000,
  parameter int unsigned CH2_BASE = 'h3000,
  parameter int unsigned ID_BASE  = 'h2280,
  parameter int unsigned ID_BITS  = 4,
  parameter logic [3:0]  BOARD_ID = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    drv_irq,
  input  logic [DATA_W-1:0] tf_rdata,
  output logic              card_irq,
  output logic [NCH-1:0]    tf_cs,
  output logic              tf_alt,
  output logic [REG_W-1:0]  tf_reg,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic              win_en,
  output logic              dma_ch
);
  logic [1:0]         rst_sync;
  logic               rst_i_n;
  logic [NCH-1:0]     tf_hit, alt_hit, ictl_hit, stat_hit;
  logic [ID_BITS-1:0] id_hit;
  logic               cfg_hit;
  logic [REG_W-1:0]   tf_idx;
  logic [NCH-1:0]     irq_en;
  logic               strobe;
  logic               any_cs;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  ide2_addr_dec #(
    .ADDR_W(ADDR_W), .STEP(STEP), .CH1_BASE(CH1_BASE), .CH2_BASE(CH2_BASE),
    .ID_BASE(ID_BASE), .ID_BITS(ID_BITS)
  ) u_dec (
    .addr(bus_addr), .win_en(win_en), .tf_hit(tf_hit), .alt_hit(alt_hit),
    .ictl_hit(ictl_hit), .stat_hit(stat_hit), .id_hit(id_hit),
    .cfg_hit(cfg_hit), .tf_idx(tf_idx)
  );

  ide2_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_i_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .ictl_hit(ictl_hit), .irq_en(irq_en)
  );

  ide2_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .we(bus_wr && cfg_hit), .wdata(bus_wdata),
    .win_en(win_en), .dma_ch(dma_ch)
  );

  assign card_irq = |(drv_irq & irq_en);

  // drive-side pass-through
  always_comb begin
    strobe = bus_rd || bus_wr;
    tf_cs  = (tf_hit | alt_hit) & {NCH{strobe}};
    any_cs = |tf_cs;
    tf_alt = any_cs && |alt_hit;
    tf_reg = (any_cs && |tf_hit) ? tf_idx : '0;
    tf_rd  = any_cs && bus_rd;
    tf_wr  = any_cs && bus_wr;
  end

  // read data return
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (any_cs) bus_rdata = tf_rdata;
      for (int c = 0; c < NCH; c++) begin
        if (stat_hit[c]) bus_rdata = DATA_W'(drv_irq[c]);
      end
      for (int i = 0; i < ID_BITS; i++) begin
        if (id_hit[i]) bus_rdata = DATA_W'(BOARD_ID[i]);
      end
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(tf_cs));                                                      // R8
  AST_WIN_CLOSED: assert property (@(posedge clk) disable iff (!rst_i_n)
    !win_en |-> (tf_cs == '0));                                            // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_en == '0) |-> !card_irq);                                         // R6
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_rd |-> (bus_rdata == '0));                                        // R10
endmodule

// File: tb/sim_ide2_decoder.sv
module sim_ide2_decoder;
  typedef struct packed {
    logic [13:0] addr;
    logic        wr;
    logic        rd;
    logic [7:0]  wd;
    logic [1:0]  drv;
    logic [7:0]  e_rd;
    logic [1:0]  e_cs;
    logic [2:0]  e_reg;
    logic        e_alt;
    logic        e_irq;
    logic        e_win;
    logic        e_dma;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t row(int a, int w, int r, int wd, int drv, int erd,
                               int ecs, int ereg, int ealt, int eirq,
                               int ewin, int edma, int req);
    vec_t v;
    v.addr = 14'(a);  v.wr = 1'(w);  v.rd = 1'(r);  v.wd = 8'(wd);
    v.drv = 2'(drv);  v.e_rd = 8'(erd);  v.e_cs = 2'(ecs);  v.e_reg = 3'(ereg);
    v.e_alt = 1'(ealt);  v.e_irq = 1'(eirq);  v.e_win = 1'(ewin);
    v.e_dma = 1'(edma);  v.req = 4'(req);
    return v;
  endfunction

  localparam int NROW = 33;
  //                       addr  wr rd wd  drv erd  cs reg alt irq win dma req
  localparam vec_t TBL [NROW] = '{
    row('h2280, 0,1,'h00, 0,'h01, 0,0,0,0, 0,0, 2),  // R2 id bit0
    row('h2284, 0,1,'h00, 0,'h01, 0,0,0,0, 0,0, 2),  // R2 id bit1
    row('h2288, 0,1,'h00, 0,'h00, 0,0,0,0, 0,0, 2),  // R2 id bit2
    row('h228C, 0,1,'h00, 0,'h00, 0,0,0,0, 0,0, 2),  // R2 id bit3
    row('h2000, 0,1,'h00, 0,'h00, 0,0,0,0, 0,0, 4),  // R4 closed window
    row('h2200, 1,0,'h00, 3,'h00, 0,0,0,0, 0,0, 4),  // R4 arm attempt ignored
    row('h0000, 0,0,'h00, 3,'h00, 0,0,0,0, 0,0, 4),  // R4 still disarmed
    row('h0000, 1,0,'h21, 0,'h00, 0,0,0,0, 0,0, 3),  // R3 open, dma ch2
    row('h2280, 0,1,'h00, 0,'h00, 0,0,0,0, 1,1, 10), // R10 id hidden
    row('h2000, 0,1,'h00, 0,'hA5, 1,0,0,0, 1,1, 8),  // R8 data reg
    row('h21C0, 1,0,'h33, 0,'h00, 1,7,0,0, 1,1, 8),  // R8 last slot
    row('h3140, 0,1,'h00, 0,'hA5, 2,5,0,0, 1,1, 8),  // R8 ch2 slot 5
    row('h3380, 0,1,'h00, 0,'hA5, 2,0,1,0, 1,1, 9),  // R9 ch2 alt
    row('h2380, 0,1,'h00, 0,'hA5, 1,0,1,0, 1,1, 9),  // R9 ch1 alt
    row('h2290, 0,1,'h00, 1,'h01, 0,0,0,0, 1,1, 7),  // R7 raw while disarmed
    row('h3290, 0,1,'h00, 1,'h00, 0,0,0,0, 1,1, 7),  // R7 ch2 quiet
    row('h2200, 1,0,'h5A, 1,'h00, 0,0,0,0, 1,1, 5),  // R5 arm ch1
    row('h0000, 0,0,'h00, 1,'h00, 0,0,0,1, 1,1, 5),  // R5 armed
    row('h0000, 0,0,'h00, 2,'h00, 0,0,0,0, 1,1, 6),  // R6 ch2 not armed
    row('h3200, 1,0,'h00, 2,'h00, 0,0,0,0, 1,1, 5),  // R5 arm ch2
    row('h0000, 0,0,'h00, 2,'h00, 0,0,0,1, 1,1, 6),  // R6 ch2 fires
    row('h2200, 0,1,'h00, 0,'h00, 0,0,0,0, 1,1, 5),  // R5 disarm ch1
    row('h0000, 0,0,'h00, 1,'h00, 0,0,0,0, 1,1, 5),  // R5 ch1 disarmed
    row('h0000, 0,0,'h00, 3,'h00, 0,0,0,1, 1,1, 6),  // R6 OR of channels
    row('h3290, 0,1,'h00, 3,'h01, 0,0,0,1, 1,1, 7),  // R7 ch2 raw
    row('h2400, 0,1,'h00, 0,'h00, 0,0,0,0, 1,1, 10), // R10 past span
    row('h2041, 1,0,'h77, 0,'h00, 0,0,0,0, 1,1, 10), // R10 misaligned
    row('h0000, 1,0,'hDE, 0,'h00, 0,0,0,0, 1,1, 3),  // R3 other bits only
    row('h2284, 0,1,'h00, 0,'h01, 0,0,0,0, 0,0, 3),  // R3 closed again
    row('h0000, 0,0,'h00, 2,'h00, 0,0,0,1, 0,0, 6),  // R6 latch kept
    row('h0000, 1,0,'h01, 0,'h00, 0,0,0,0, 0,0, 3),  // R3 dma only
    row('h0000, 0,0,'h00, 0,'h00, 0,0,0,0, 0,1, 3),  // R3 dma ch2, closed
    row('h3000, 0,1,'h00, 0,'h00, 0,0,0,0, 0,1, 4)   // R4 closed window
  };

  logic        clk;
  logic        rst_n;
  logic [13:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata, tf_rdata;
  logic [1:0]  drv_irq, tf_cs;
  logic        card_irq, tf_alt, tf_rd, tf_wr, win_en, dma_ch;
  logic [2:0]  tf_reg;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  ide2_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .tf_rdata(tf_rdata), .card_irq(card_irq),
    .tf_cs(tf_cs), .tf_alt(tf_alt), .tf_reg(tf_reg), .tf_rd(tf_rd),
    .tf_wr(tf_wr), .win_en(win_en), .dma_ch(dma_ch)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    drv_irq = 2'b11; tf_rdata = 8'hA5;
    repeat (2) @(negedge clk);
    #2 chk("R1 in reset", {31'd0, card_irq} | {29'd0, win_en, dma_ch, 1'b0}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2 chk("R1 after release", {28'd0, card_irq, win_en, dma_ch, |tf_cs}, 32'd0);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      bus_addr = TBL[i].addr; bus_wr = TBL[i].wr; bus_rd = TBL[i].rd;
      bus_wdata = TBL[i].wd; drv_irq = TBL[i].drv;
      #2;
      checks++;
      if ({bus_rdata, tf_cs, tf_reg, tf_alt, card_irq, win_en, dma_ch, tf_rd, tf_wr} !==
          {TBL[i].e_rd, TBL[i].e_cs, TBL[i].e_reg, TBL[i].e_alt, TBL[i].e_irq,
           TBL[i].e_win, TBL[i].e_dma, TBL[i].rd & (|TBL[i].e_cs),
           TBL[i].wr & (|TBL[i].e_cs)}) begin
        errors++;
        $display("FAIL R%0d row %0d act %h exp %h", TBL[i].req, i,
          {bus_rdata, tf_cs, tf_reg, tf_alt, card_irq, win_en, dma_ch, tf_rd, tf_wr},
          {TBL[i].e_rd, TBL[i].e_cs, TBL[i].e_reg, TBL[i].e_alt, TBL[i].e_irq,
           TBL[i].e_win, TBL[i].e_dma, TBL[i].rd & (|TBL[i].e_cs),
           TBL[i].wr & (|TBL[i].e_cs)});
      end
    end

    // directed: reset in mid-run clears the armed channel 2 latch and dma steering (R1)
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_addr = '0; drv_irq = 2'b11;
    #2 chk("R1 armed before reset", {31'd0, card_irq}, 32'd1);
    @(negedge clk) rst_n = 1'b0;
    #2 chk("R1 mid-run reset", {29'd0, card_irq, win_en, dma_ch}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2 chk("R1 stays clear", {29'd0, card_irq, win_en, dma_ch}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule